// File: doc/BRIEF.md
# Decimal Step-Select Counter

This block keeps a single decimal digit, 0 through 9, and on every rising clock edge changes it by an amount chosen on a 2-bit control input. The digit can stay where it is, advance by one, advance by two, or go back by one. Every move wraps inside the ten legal values, so the digit never leaves the decimal range. A synchronous reset, active low, returns it to zero.

The digit is kept as an explicit ten-state machine. The next state comes from a case over the present state and the control code. The block drives the digit as a 4-bit BCD value. It also drives a 7-segment pattern for the same digit, so one display can be connected without extra logic.

Top module: `decade_stepper`

## Requirements
- R1: When `rst_n` is 0 at a rising clock edge, `count_bcd` is 0 after that edge.
- R2: With `rst_n` high and `step_sel` = 2'b00, `count_bcd` keeps its value across the edge.
- R3: With `step_sel` = 2'b01, `count_bcd` becomes (count + 1) mod 10, so 9 goes to 0.
- R4: With `step_sel` = 2'b10, `count_bcd` becomes (count + 2) mod 10, so 8 goes to 0 and 9 goes to 1.
- R5: With `step_sel` = 2'b11, `count_bcd` becomes (count + 9) mod 10, so 0 goes to 9.
- R6: `count_bcd` never holds a value above 9.
- R7: `seg_n` is active low, with bit 6 down to bit 0 driving segments g,f,e,d,c,b,a. The patterns for digits 0 to 9 are 40,79,24,30,19,12,02,78,00,10 (hex).
- R8: The reset takes priority over any `step_sel` code at the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes happen on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| step_sel | input | 2 | Step code: 00 hold, 01 add one, 10 add two, 11 subtract one |
| count_bcd | output | 4 | Current digit in BCD |
| seg_n | output | 7 | Active-low segment pattern for the digit, gfedcba order |

## Verification
The assertions assume that `rst_n` and `step_sel` are known, not X, at every rising edge. They also assume that the first edge sees the reset asserted, so the state starts from a defined value. The bench drives both inputs only on falling edges. It holds reset low for the first cycles, and it takes each step code from a fixed-seed random draw limited to two bits. As a result, every edge sees a legal, stable code.

// File: rtl/decade_stepper_pkg.sv
package decade_stepper_pkg;

    localparam int DIGIT_W = 4;
    localparam int SEG_W   = 7;
    localparam int NUM_DIGITS = 10;

    typedef enum logic [DIGIT_W-1:0] {
        D0 = 4'd0, D1 = 4'd1, D2 = 4'd2, D3 = 4'd3, D4 = 4'd4,
        D5 = 4'd5, D6 = 4'd6, D7 = 4'd7, D8 = 4'd8, D9 = 4'd9
    } digit_state_e;

    typedef enum logic [1:0] {
        STEP_HOLD = 2'b00,
        STEP_UP1  = 2'b01,
        STEP_UP2  = 2'b10,
        STEP_DN1  = 2'b11
    } step_code_e;

    typedef struct packed {
        digit_state_e back1;
        digit_state_e fwd1;
        digit_state_e fwd2;
    } neighbours_t;

    typedef struct packed {
        digit_state_e st;
    } stepper_regs_t;

endpackage

// File: rtl/stepper_next.sv
module stepper_next
    import decade_stepper_pkg::*;
(
    input  digit_state_e cur_state,
    input  logic [1:0]   code,
    output digit_state_e nxt_state
);

    neighbours_t nb;

    always_comb begin
        case (cur_state)
            D0:      nb = '{back1: D9, fwd1: D1, fwd2: D2};
            D1:      nb = '{back1: D0, fwd1: D2, fwd2: D3};
            D2:      nb = '{back1: D1, fwd1: D3, fwd2: D4};
            D3:      nb = '{back1: D2, fwd1: D4, fwd2: D5};
            D4:      nb = '{back1: D3, fwd1: D5, fwd2: D6};
            D5:      nb = '{back1: D4, fwd1: D6, fwd2: D7};
            D6:      nb = '{back1: D5, fwd1: D7, fwd2: D8};
            D7:      nb = '{back1: D6, fwd1: D8, fwd2: D9};
            D8:      nb = '{back1: D7, fwd1: D9, fwd2: D0};
            D9:      nb = '{back1: D8, fwd1: D0, fwd2: D1};
            default: nb = '{back1: D0, fwd1: D0, fwd2: D0};
        endcase
    end

    always_comb begin
        case (step_code_e'(code))
            STEP_HOLD: nxt_state = cur_state;
            STEP_UP1:  nxt_state = nb.fwd1;
            STEP_UP2:  nxt_state = nb.fwd2;
            STEP_DN1:  nxt_state = nb.back1;
            default:   nxt_state = cur_state;
        endcase
    end

endmodule

// File: rtl/digit_segments.sv
module digit_segments
    import decade_stepper_pkg::*;
#(
    parameter bit ACTIVE_LOW = 1'b1
) (
    input  logic [DIGIT_W-1:0] digit,
    output logic [SEG_W-1:0]   seg
);

    logic [SEG_W-1:0] lit;

    always_comb begin
        case (digit)
            4'd0:    lit = 7'b0111111;
            4'd1:    lit = 7'b0000110;
            4'd2:    lit = 7'b1011011;
            4'd3:    lit = 7'b1001111;
            4'd4:    lit = 7'b1100110;
            4'd5:    lit = 7'b1101101;
            4'd6:    lit = 7'b1111101;
            4'd7:    lit = 7'b0000111;
            4'd8:    lit = 7'b1111111;
            4'd9:    lit = 7'b1101111;
            default: lit = 7'b1000000;
        endcase
    end

    generate
        if (ACTIVE_LOW) begin : g_low
            assign seg = ~lit;
        end else begin : g_high
            assign seg = lit;
        end
    endgenerate

endmodule

// File: rtl/decade_stepper.sv
module decade_stepper
    import decade_stepper_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         step_sel,
    output logic [DIGIT_W-1:0] count_bcd,
    output logic [SEG_W-1:0]   seg_n
);

    stepper_regs_t regs_d, regs_q;
    digit_state_e  step_st;

    stepper_next i_next (
        .cur_state (regs_q.st),
        .code      (step_sel),
        .nxt_state (step_st)
    );

    always_comb begin
        regs_d = regs_q;
        if (!rst_n) begin
            regs_d.st = D0;
        end else begin
            regs_d.st = step_st;
        end
    end

    always_ff @(posedge clk) begin
        regs_q <= regs_d;
    end

    assign count_bcd = regs_q.st;

    digit_segments #(.ACTIVE_LOW(1'b1)) i_seg (
        .digit (count_bcd),
        .seg   (seg_n)
    );

    AST_RESET_TO_ZERO: assert property (@(posedge clk)
        !rst_n |=> count_bcd == 4'd0);  // R1 R8

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        step_sel == 2'b00 |=> $stable(count_bcd));  // R2

    AST_UP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        step_sel == 2'b01 |=> count_bcd == (($past(count_bcd) == 4'd9) ? 4'd0 : $past(count_bcd) + 4'd1));  // R3

    AST_UP_TWO: assert property (@(posedge clk) disable iff (!rst_n)
        step_sel == 2'b10 |=> count_bcd == (($past(count_bcd) >= 4'd8) ? $past(count_bcd) - 4'd8 : $past(count_bcd) + 4'd2));  // R4

    AST_DOWN_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        step_sel == 2'b11 |=> count_bcd == (($past(count_bcd) == 4'd0) ? 4'd9 : $past(count_bcd) - 4'd1));  // R5

    AST_DIGIT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        count_bcd <= 4'd9);  // R6

    AST_SEG_EIGHT_ALL_ON: assert property (@(posedge clk) disable iff (!rst_n)
        count_bcd == 4'd8 |-> seg_n == 7'h00);  // R7

endmodule

// File: tb/test_decade_stepper.sv
module test_decade_stepper;

    localparam time CLK_PERIOD = 10ns;
    localparam int  RAND_CYCLES = 3000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] step_sel = 2'b00;
    logic [3:0] count_bcd;
    logic [6:0] seg_n;

    int checks = 0;
    int errors = 0;
    int model  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    decade_stepper i_decade_stepper (
        .clk       (clk),
        .rst_n     (rst_n),
        .step_sel  (step_sel),
        .count_bcd (count_bcd),
        .seg_n     (seg_n)
    );

    function automatic int next_digit(input int cur, input logic r, input logic [1:0] s);
        if (!r) return 0;
        case (s)
            2'b00:   return cur;
            2'b01:   return (cur + 1) % 10;
            2'b10:   return (cur + 2) % 10;
            default: return (cur + 9) % 10;
        endcase
    endfunction

    function automatic logic [6:0] seg_of(input int d);
        case (d)
            0: return 7'h40; 1: return 7'h79; 2: return 7'h24; 3: return 7'h30;
            4: return 7'h19; 5: return 7'h12; 6: return 7'h02; 7: return 7'h78;
            8: return 7'h00; default: return 7'h10;
        endcase
    endfunction

    function automatic string tag_of(input logic r, input logic [1:0] s);
        if (!r) return (s != 2'b00) ? "R8" : "R1";
        case (s)
            2'b00:   return "R2";
            2'b01:   return "R3";
            2'b10:   return "R4";
            default: return "R5";
        endcase
    endfunction

    task automatic cyc(input logic r, input logic [1:0] s);
        string t;
        rst_n = r;
        step_sel = s;
        t = tag_of(r, s);
        @(posedge clk);
        model = next_digit(model, r, s);
        @(negedge clk);
        checks++;
        if (count_bcd !== 4'(model)) begin
            errors++;
            $display("FAIL %s count actual %0d expected %0d", t, count_bcd, model);
        end
        checks++;
        if (count_bcd > 4'd9) begin
            errors++;
            $display("FAIL R6 count actual %0d expected <=9", count_bcd);
        end
        checks++;
        if (seg_n !== seg_of(model)) begin
            errors++;
            $display("FAIL R7 seg actual %h expected %h", seg_n, seg_of(model));
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog actual timeout expected finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        @(negedge clk);
        cyc(1'b0, 2'b00);   // R1 reset state
        cyc(1'b0, 2'b00);

        // every start digit with every step code
        for (int d = 0; d < 10; d++) begin
            for (int c = 0; c < 4; c++) begin
                cyc(1'b0, 2'b00);
                for (int k = 0; k < d; k++) cyc(1'b1, 2'b01);
                cyc(1'b1, 2'(c));
            end
        end

        // wrap corners: R3 9->0, R4 8->0 and 9->1, R5 0->9
        cyc(1'b0, 2'b00); cyc(1'b1, 2'b11);
        cyc(1'b1, 2'b01);
        cyc(1'b1, 2'b11); cyc(1'b1, 2'b11); cyc(1'b1, 2'b10);
        cyc(1'b1, 2'b11); cyc(1'b1, 2'b10); cyc(1'b1, 2'b10);

        // R8 reset with nonzero code
        cyc(1'b1, 2'b10);
        cyc(1'b0, 2'b11);
        cyc(1'b1, 2'b10);
        cyc(1'b0, 2'b01);

        for (int i = 0; i < RAND_CYCLES; i++) begin
            logic r;
            r = ($urandom_range(0, 29) != 0);
            cyc(r, 2'($urandom_range(0, 3)));
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule